// File: doc/BRIEF.md
# Block Reset Group Controller

This controller sits between the row-load path and the reset drivers of a mirror array divided into 16 horizontal blocks of 48 rows. A reset request names a block index and is widened to a group of reset lines by the current grouping mode: one block, an aligned pair, an aligned group of four, or every block at once. Each selected line pulses for one clock cycle.

Each block has its own settle-time lockout. When a block's reset line pulses, its countdown is loaded with the settle length presented with the request. Until that countdown expires the block's load-enable bit stays low, and any row load aimed at it is refused. Blocks outside the group being reset can keep taking data. A row index is turned into a block index by dividing it by the rows per block. The reject flag reports each refused load one cycle after the request.

Top module: `rstgrp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows all reset lines low, every load-enable bit high and the reject flag low.
- R2: With `grp_mode` = 0 (single), a request for index i raises only line i in the cycle after the request.
- R3: With `grp_mode` = 1 (pair), a request raises lines 2k and 2k+1 with k = i/2. Bit 0 of the index has no effect.
- R4: With `grp_mode` = 2 (four), a request raises lines 4k to 4k+3 with k = i/4. Bits 1:0 of the index have no effect.
- R5: With `grp_mode` = 3 (all), a request raises all 16 lines, and the index has no effect.
- R6: A reset line is high for exactly the one cycle after each edge at which a request covering it was sampled. With no request, all lines are low.
- R7: Let S be the value of `settle_cycles` sampled with a request. Each covered block's load-enable bit is low for max(S,1) cycles, starting in its pulse cycle, and high after that. A block is never load-enabled while its line is high.
- R8: A new reset that covers a block which is still settling restarts that block's lockout with the new S. Blocks outside the new group keep their own countdowns.
- R9: A load request for row r < 768 targets block r/48. The reject flag is high in the next cycle exactly when that block's load-enable bit was low in the request cycle. Loads to other blocks are accepted while a block settles.
- R10: A load request for a row of 768 or more is always rejected in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_mode | input | 2 | Grouping: 0 single, 1 pair, 2 four, 3 all |
| rst_req | input | 1 | Reset request strobe |
| rst_idx | input | 4 | Requested block index |
| settle_cycles | input | 16 | Lockout length captured with a request |
| ld_req | input | 1 | Row-load request strobe |
| ld_row | input | 10 | Target row of the load |
| rst_line | output | 16 | One-cycle reset pulses, one per block |
| ld_en | output | 16 | Per-block load permission |
| ld_rej | output | 1 | Load refused (registered, one cycle after request) |

## Verification
On every cycle the assertions check the population count of the reset lines for each grouping mode, that no line pulses without a request, and that no block is load-enabled while its line is high. They also check that reject decisions follow the target block's permission and the row range. Three behaviours are shown only by the bench's scenarios against its behavioural model: the exact members chosen for each group, the length of every lockout, and a lockout restarting when a settling block is reset again. Loads into other blocks during a settle are also covered only there.

// File: rtl/rstgrp_pkg.sv
package rstgrp_pkg;
  typedef enum logic [1:0] {
    GRP_ONE  = 2'd0,
    GRP_PAIR = 2'd1,
    GRP_FOUR = 2'd2,
    GRP_ALL  = 2'd3
  } grp_mode_e;
endpackage

// File: rtl/rstgrp_mask.sv
module rstgrp_mask
  import rstgrp_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = $clog2(NUM_BLK)
) (
  input  grp_mode_e          mode_i,
  input  logic [BLK_W-1:0]   idx_i,
  output logic [NUM_BLK-1:0] mask_o
);
  // A block is covered when its index matches the request above the
  // bits that the grouping mode drops.
  always_comb begin
    for (int b = 0; b < NUM_BLK; b++) begin
      logic [BLK_W-1:0] bv;
      bv = BLK_W'(b);
      unique case (mode_i)
        GRP_ONE:  mask_o[b] = (bv == idx_i);
        GRP_PAIR: mask_o[b] = ((bv >> 1) == (idx_i >> 1));
        GRP_FOUR: mask_o[b] = ((bv >> 2) == (idx_i >> 2));
        default:  mask_o[b] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rstgrp_row2blk.sv
module rstgrp_row2blk #(
  parameter int NUM_BLK  = 16,
  parameter int ROWS_BLK = 48,
  parameter int BLK_W    = $clog2(NUM_BLK),
  parameter int ROW_W    = $clog2(NUM_BLK * ROWS_BLK)
) (
  input  logic [ROW_W-1:0] row_i,
  output logic [BLK_W-1:0] blk_o,
  output logic             valid_o
);
  localparam int ROWS_TOTAL = NUM_BLK * ROWS_BLK;

  // Division by a constant block height: count the block boundaries
  // that lie at or below the row.
  logic [NUM_BLK-1:0] past_edge;

  generate
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_edge
      if (k == 0) begin : g_zero
        assign past_edge[k] = 1'b0;
      end else begin : g_cmp
        assign past_edge[k] = ({1'b0, row_i} >= (ROW_W+1)'(k * ROWS_BLK));
      end
    end
  endgenerate

  always_comb begin
    blk_o = '0;
    for (int k = 1; k < NUM_BLK; k++)
      if (past_edge[k]) blk_o = BLK_W'(k);
  end

  assign valid_o = ({1'b0, row_i} < (ROW_W+1)'(ROWS_TOTAL));
endmodule

// File: rtl/rstgrp_settle.sv
module rstgrp_settle #(
  parameter int NUM_BLK  = 16,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BLK-1:0]  hit_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [NUM_BLK-1:0]  busy_o
);
  // Each block owns a countdown that reloads on every reset covering it.
  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      logic [SETTLE_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (hit_i[b])      cnt_q <= settle_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o[b] = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/rstgrp_ctrl.sv
module rstgrp_ctrl
  import rstgrp_pkg::*;
#(
  parameter int NUM_BLK  = 16,
  parameter int ROWS_BLK = 48,
  parameter int SETTLE_W = 16,
  parameter int BLK_W    = $clog2(NUM_BLK),
  parameter int ROW_W    = $clog2(NUM_BLK * ROWS_BLK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          grp_mode,
  input  logic                rst_req,
  input  logic [BLK_W-1:0]    rst_idx,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                ld_req,
  input  logic [ROW_W-1:0]    ld_row,
  output logic [NUM_BLK-1:0]  rst_line,
  output logic [NUM_BLK-1:0]  ld_en,
  output logic                ld_rej
);
  logic [NUM_BLK-1:0] grp_mask;
  logic [NUM_BLK-1:0] hit;
  logic [NUM_BLK-1:0] busy;
  logic [NUM_BLK-1:0] line_q;
  logic [BLK_W-1:0]   tgt_blk;
  logic               tgt_ok;
  logic               rej_q;

  rstgrp_mask #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_mask (
    .mode_i (grp_mode_e'(grp_mode)),
    .idx_i  (rst_idx),
    .mask_o (grp_mask)
  );

  assign hit = rst_req ? grp_mask : '0;

  rstgrp_settle #(.NUM_BLK(NUM_BLK), .SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (hit),
    .settle_i (settle_cycles),
    .busy_o   (busy)
  );

  rstgrp_row2blk #(
    .NUM_BLK(NUM_BLK), .ROWS_BLK(ROWS_BLK), .BLK_W(BLK_W), .ROW_W(ROW_W)
  ) u_row (
    .row_i   (ld_row),
    .blk_o   (tgt_blk),
    .valid_o (tgt_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      line_q <= hit;
      rej_q  <= ld_req & (~tgt_ok | ~ld_en[tgt_blk]);
    end
  end

  assign rst_line = line_q;
  assign ld_en    = ~(line_q | busy);
  assign ld_rej   = rej_q;
endmodule

// File: rtl/rstgrp_ctrl_chk.sv
module rstgrp_ctrl_chk #(
  parameter int NUM_BLK  = 16,
  parameter int ROWS_BLK = 48,
  parameter int BLK_W    = 4,
  parameter int ROW_W    = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         grp_mode,
  input logic               rst_req,
  input logic               ld_req,
  input logic [ROW_W-1:0]   ld_row,
  input logic [NUM_BLK-1:0] rst_line,
  input logic [NUM_BLK-1:0] ld_en,
  input logic               ld_rej
);
  localparam int ROWS_TOTAL = NUM_BLK * ROWS_BLK;

  logic in_range;
  logic tgt_free;
  assign in_range = (int'(ld_row) < ROWS_TOTAL);
  assign tgt_free = in_range ? ld_en[int'(ld_row) / ROWS_BLK] : 1'b0;

  a_r2_single_one: assert property (@(posedge clk) disable iff (rst)
    (rst_req && grp_mode == 2'd0) |=> ($countones(rst_line) == 1));

  a_r3_pair_two: assert property (@(posedge clk) disable iff (rst)
    (rst_req && grp_mode == 2'd1) |=> ($countones(rst_line) == 2));

  a_r4_four_lines: assert property (@(posedge clk) disable iff (rst)
    (rst_req && grp_mode == 2'd2) |=> ($countones(rst_line) == 4));

  a_r5_all_lines: assert property (@(posedge clk) disable iff (rst)
    (rst_req && grp_mode == 2'd3) |=> (&rst_line));

  a_r6_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
    (!rst_req) |=> (rst_line == '0));

  a_r7_locked_in_pulse: assert property (@(posedge clk) disable iff (rst)
    ((rst_line & ld_en) == '0));

  a_r9_accept_free: assert property (@(posedge clk) disable iff (rst)
    (ld_req && tgt_free) |=> !ld_rej);

  a_r9_reject_locked: assert property (@(posedge clk) disable iff (rst)
    (ld_req && in_range && !tgt_free) |=> ld_rej);

  a_r10_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !in_range) |=> ld_rej);
endmodule

bind rstgrp_ctrl rstgrp_ctrl_chk #(
  .NUM_BLK(NUM_BLK), .ROWS_BLK(ROWS_BLK), .BLK_W(BLK_W), .ROW_W(ROW_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .grp_mode (grp_mode),
  .rst_req  (rst_req),
  .ld_req   (ld_req),
  .ld_row   (ld_row),
  .rst_line (rst_line),
  .ld_en    (ld_en),
  .ld_rej   (ld_rej)
);

// File: tb/rstgrp_ctrl_test.sv
`timescale 1ns/1ps
module rstgrp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  grp_mode = 2'd0;
  logic        rst_req = 1'b0;
  logic [3:0]  rst_idx = '0;
  logic [15:0] settle_cycles = '0;
  logic        ld_req = 1'b0;
  logic [9:0]  ld_row = '0;
  logic [15:0] rst_line;
  logic [15:0] ld_en;
  logic        ld_rej;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rstgrp_ctrl uut (
    .clk(clk), .rst(rst), .grp_mode(grp_mode), .rst_req(rst_req),
    .rst_idx(rst_idx), .settle_cycles(settle_cycles), .ld_req(ld_req),
    .ld_row(ld_row), .rst_line(rst_line), .ld_en(ld_en), .ld_rej(ld_rej)
  );

  // Behavioural reference model
  int m_cnt[16];
  bit m_line[16];
  bit m_rej;

  function automatic bit m_en(int b);
    return !(m_line[b] || m_cnt[b] > 0);
  endfunction

  function automatic bit covers(int mode, int idx, int b);
    case (mode)
      0: return b == idx;
      1: return (b / 2) == (idx / 2);
      2: return (b / 4) == (idx / 4);
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cnt[b]) begin m_cnt[b] = 0; m_line[b] = 0; end
      m_rej = 0;
    end else begin
      if (ld_req) begin
        if (ld_row >= 768) m_rej = 1;
        else m_rej = !m_en(int'(ld_row) / 48);
      end else m_rej = 0;
      for (int b = 0; b < 16; b++) begin
        if (rst_req && covers(grp_mode, rst_idx, b)) begin
          m_cnt[b] = settle_cycles; m_line[b] = 1;
        end else begin
          m_line[b] = 0;
          if (m_cnt[b] > 0) m_cnt[b]--;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] el, ee;
      for (int b = 0; b < 16; b++) begin el[b] = m_line[b]; ee[b] = m_en(b); end
      check(rst_line == el, "R2 R3 R4 R5 R6 lines", rst_line, el);
      check(ld_en == ee, "R7 R8 load enable", ld_en, ee);
      check(ld_rej == m_rej, "R9 R10 reject", ld_rej, m_rej);
    end
  end

  task automatic step(bit rq, int md, int ix, int s, bit lq, int row);
    rst_req = rq; grp_mode = 2'(md); rst_idx = 4'(ix);
    settle_cycles = 16'(s); ld_req = lq; ld_row = 10'(row);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rst_line == 16'h0, "R1 lines", rst_line, 0);
    check(ld_en == 16'hffff, "R1 enable", ld_en, 16'hffff);
    check(ld_rej == 1'b0, "R1 reject", ld_rej, 0);
    rst = 0;
    idle(2);

    // R2: single block 5 with S=4, loads to block 5 and block 6
    step(1, 0, 5, 4, 0, 0);
    check(rst_line == 16'h0020, "R2 single line", rst_line, 16'h0020);
    step(0, 0, 0, 0, 1, 5*48+3);
    check(ld_rej == 1'b1, "R9 locked reject", ld_rej, 1);
    step(0, 0, 0, 0, 1, 6*48);
    check(ld_rej == 1'b0, "R9 other block accepted", ld_rej, 0);
    idle(4);
    check(ld_en[5] == 1'b1, "R7 lock released", ld_en[5], 1);

    // R3: pair, index 7 -> lines 6,7
    step(1, 1, 7, 2, 0, 0);
    check(rst_line == 16'h00c0, "R3 pair lines", rst_line, 16'h00c0);
    idle(3);
    // R4: four, index 9 -> lines 8..11
    step(1, 2, 9, 0, 0, 0);
    check(rst_line == 16'h0f00, "R4 four lines", rst_line, 16'h0f00);
    check(ld_en[11:8] == 4'h0, "R7 S=0 pulse-cycle lock", ld_en[11:8], 0);
    step(0, 0, 0, 0, 0, 0);
    check(ld_en[11:8] == 4'hf, "R7 S=0 one-cycle lock", ld_en[11:8], 4'hf);
    // R5: all lines
    step(1, 3, 2, 3, 0, 0);
    check(rst_line == 16'hffff, "R5 all lines", rst_line, 16'hffff);
    step(0, 0, 0, 0, 0, 0);
    check(rst_line == 16'h0, "R6 single-cycle pulse", rst_line, 0);
    idle(4);

    // R8: restart of a settling block
    step(1, 0, 3, 10, 0, 0);
    idle(4);
    step(1, 0, 3, 3, 0, 0);
    idle(2);
    check(ld_en[3] == 1'b0, "R8 still locked after restart", ld_en[3], 0);
    idle(1);
    check(ld_en[3] == 1'b1, "R8 restart uses new length", ld_en[3], 1);

    // R10: out-of-range rows and last valid row
    step(0, 0, 0, 0, 1, 800);
    check(ld_rej == 1'b1, "R10 row 800", ld_rej, 1);
    step(0, 0, 0, 0, 1, 767);
    check(ld_rej == 1'b0, "R10 row 767 valid", ld_rej, 0);
    step(0, 0, 0, 0, 1, 768);
    check(ld_rej == 1'b1, "R10 row 768", ld_rej, 1);
    idle(2);

    // Mixed random traffic checked by the model
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) == 0, $urandom % 4, $urandom % 16, $urandom % 7,
           $urandom % 2, $urandom % 820);
    idle(8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule